// File: doc/BRIEF.md
# UART Interrupt Source Generator

This block turns the status of a UART's transmit path, receive path and modem control lines into interrupt requests. It watches the fill levels of the transmit and receive FIFOs (or, with FIFOs switched off, the single holding register and receive buffer), a bit-period tick from the baud logic, the modem flow-control inputs, and strobes from the register interface. From these it keeps four pending sources: transmit, receive, modem change and receive idle timeout.

Each source is a small state machine. The transmit source has states TX_QUIET and TX_PEND. The receive source has states RX_QUIET and RX_PEND. The modem source has states MD_STILL and MD_CHANGED. The timeout source has states TO_IDLE, TO_COUNT and TO_FIRED.

- TX_QUIET→TX_PEND happens on a low FIFO level, or on an empty holding register with no write.
- TX_PEND→TX_QUIET happens on a high FIFO level, or on a holding-register write.
- RX_QUIET→RX_PEND happens when the FIFO reaches half, or the buffer is full and not being read.
- RX_PEND→RX_QUIET happens when the FIFO falls below half, or on a buffer read.
- MD_STILL→MD_CHANGED happens on a synchronized input change.
- MD_CHANGED→MD_STILL happens on a status write with no new change.
- TO_IDLE→TO_COUNT happens when the FIFO holds data.
- TO_COUNT→TO_FIRED happens when the tick limit is reached.
- Any timeout state returns to TO_IDLE when the FIFO is empty or FIFO mode is off.

The four raw pending bits are exposed for status reads. A mask selects which of them reach the transmit line, the receive line and the combined line, which is the OR of all masked sources.

Top module: `uart_irq_ctrl`

## Requirements
- R1: With fifo_en=1, the transmit source (raw_status bit 0) becomes 1 when tx_level < FIFO_DEPTH/2 and 0 when tx_level > FIFO_DEPTH/2. A level of exactly FIFO_DEPTH/2 keeps its previous value. The new value is seen one clock after the level is applied.
- R2: With fifo_en=0, the transmit source is set by thr_empty=1 and cleared by thr_write=1. A write wins over an empty indication in the same cycle. The result is visible one clock later.
- R3: With fifo_en=1, the receive source (raw_status bit 1) is 1 exactly when rx_level >= FIFO_DEPTH/2, one clock after the level is applied.
- R4: With fifo_en=0, the receive source is set by rbr_full=1 and cleared by rbr_read=1. A read wins over a full indication in the same cycle.
- R5: A change on any bit of modem_in sets the modem source (raw_status bit 2) on the third rising clock edge after the change, because the input passes through a two-stage synchronizer. modem_stat_write=1 clears the modem source when no new change is arriving.
- R6: With fifo_en=1 and rx_level nonzero, the timeout source (raw_status bit 3) sets after TIMEOUT_BITS bit_tick pulses with no rx_char or rx_read pulse. With fifo_en=0 it never sets.
- R7: A pulse on rx_char or rx_read restarts the timeout count. Once set, the timeout source stays set through reads and clears only when rx_level is 0.
- R8: irq_tx = raw bit 0 AND mask bit 0, and irq_rx = raw bit 1 AND mask bit 1. irq_any is 1 exactly when some raw bit is 1 with its mask bit 1. raw_status is never masked.
- R9: During reset, raw_status is 0 and irq_tx, irq_rx and irq_any are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single-register mode |
| tx_level | input | LVL_W | Transmit FIFO fill count |
| rx_level | input | LVL_W | Receive FIFO fill count |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_write | input | 1 | Write strobe to the transmit holding register |
| rbr_full | input | 1 | Receive buffer holds a character |
| rbr_read | input | 1 | Read strobe of the receive buffer |
| rx_char | input | 1 | Pulse: a character was received into the FIFO |
| rx_read | input | 1 | Pulse: a character was read from the receive FIFO |
| bit_tick | input | 1 | One pulse per serial bit period |
| modem_in | input | MODEM_W | Asynchronous modem flow-control inputs |
| modem_stat_write | input | 1 | Write strobe to the modem status register |
| mask | input | 4 | Per-source enable: bit 0 tx, 1 rx, 2 modem, 3 timeout |
| raw_status | output | 4 | Unmasked pending bits, same bit order as mask |
| irq_tx | output | 1 | Masked transmit interrupt line |
| irq_rx | output | 1 | Masked receive interrupt line |
| irq_any | output | 1 | OR of all masked sources |

## Verification
The bench builds the block with its default FIFO depth of 16 and a 32-tick timeout, so every fill level from 0 to 16 can be swept in both directions. This sweep reaches the hold band at exactly half full from above and from below. The 32-tick timeout keeps the exact-expiry edge cheap to hit, both from a fresh start and after a restart by a received character. All 16 mask values are applied with all four sources pending and then with none pending.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int SRC_TX  = 0;
    localparam int SRC_RX  = 1;
    localparam int SRC_MDM = 2;
    localparam int SRC_TO  = 3;
    localparam int NUM_SRC = 4;

    typedef enum logic { TX_QUIET, TX_PEND } tx_state_e;
    typedef enum logic { RX_QUIET, RX_PEND } rx_state_e;
    typedef enum logic { MD_STILL, MD_CHANGED } md_state_e;
    typedef enum logic [1:0] { TO_IDLE, TO_COUNT, TO_FIRED } to_state_e;

endpackage

// File: rtl/uart_irq_tx.sv
module uart_irq_tx
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] level,
    input  logic             thr_empty,
    input  logic             thr_write,
    output logic             pending
);

    localparam logic [LVL_W-1:0] HALF = LVL_W'(FIFO_DEPTH / 2);

    tx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_QUIET: begin
                if (fifo_en ? (level < HALF) : (thr_empty && !thr_write))
                    state_d = TX_PEND;
            end
            TX_PEND: begin
                if (fifo_en ? (level > HALF) : thr_write)
                    state_d = TX_QUIET;
            end
            default: state_d = TX_QUIET;
        endcase
    end

    assign pending = (state_q == TX_PEND);

endmodule

// File: rtl/uart_irq_rx.sv
module uart_irq_rx
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] level,
    input  logic             rbr_full,
    input  logic             rbr_read,
    output logic             pending
);

    localparam logic [LVL_W-1:0] HALF = LVL_W'(FIFO_DEPTH / 2);

    rx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_QUIET: begin
                if (fifo_en ? (level >= HALF) : (rbr_full && !rbr_read))
                    state_d = RX_PEND;
            end
            RX_PEND: begin
                if (fifo_en ? (level < HALF) : rbr_read)
                    state_d = RX_QUIET;
            end
            default: state_d = RX_QUIET;
        endcase
    end

    assign pending = (state_q == RX_PEND);

endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout
    import uart_irq_pkg::*;
#(
    parameter int LVL_W        = 5,
    parameter int TIMEOUT_BITS = 32,
    parameter int CNT_W        = $clog2(TIMEOUT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] level,
    input  logic             rx_char,
    input  logic             rx_read,
    input  logic             bit_tick,
    output logic             pending
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_BITS - 1);

    to_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!fifo_en || level == '0) begin
            state_d = TO_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TO_IDLE: begin
                    state_d = TO_COUNT;
                    cnt_d   = '0;
                end
                TO_COUNT: begin
                    if (rx_char || rx_read) begin
                        cnt_d = '0;
                    end else if (bit_tick) begin
                        if (cnt_q == LAST) begin
                            state_d = TO_FIRED;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                TO_FIRED: state_d = TO_FIRED;
                default:  state_d = TO_IDLE;
            endcase
        end
    end

    assign pending = (state_q == TO_FIRED);

endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem
    import uart_irq_pkg::*;
#(
    parameter int MODEM_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODEM_W-1:0] modem_in,
    input  logic               stat_write,
    output logic               pending
);

    logic [MODEM_W-1:0] sync1_q, sync2_q, prev_q;
    logic               change;
    md_state_e          state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
            state_q <= MD_STILL;
        end else begin
            sync1_q <= modem_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
            state_q <= state_d;
        end
    end

    assign change = |(sync2_q ^ prev_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MD_STILL:   if (change) state_d = MD_CHANGED;
            MD_CHANGED: if (stat_write && !change) state_d = MD_STILL;
            default:    state_d = MD_STILL;
        endcase
    end

    assign pending = (state_q == MD_CHANGED);

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH   = 16,
    parameter int TIMEOUT_BITS = 32,
    parameter int MODEM_W      = 4,
    parameter int LVL_W        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_en,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic               thr_empty,
    input  logic               thr_write,
    input  logic               rbr_full,
    input  logic               rbr_read,
    input  logic               rx_char,
    input  logic               rx_read,
    input  logic               bit_tick,
    input  logic [MODEM_W-1:0] modem_in,
    input  logic               modem_stat_write,
    input  logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] raw_status,
    output logic               irq_tx,
    output logic               irq_rx,
    output logic               irq_any
);

    logic [NUM_SRC-1:0] masked;

    uart_irq_tx #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .level(tx_level),
        .thr_empty(thr_empty), .thr_write(thr_write),
        .pending(raw_status[SRC_TX])
    );

    uart_irq_rx #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .level(rx_level),
        .rbr_full(rbr_full), .rbr_read(rbr_read),
        .pending(raw_status[SRC_RX])
    );

    uart_irq_modem #(.MODEM_W(MODEM_W)) u_mdm (
        .clk(clk), .rst_n(rst_n), .modem_in(modem_in),
        .stat_write(modem_stat_write),
        .pending(raw_status[SRC_MDM])
    );

    uart_irq_timeout #(.LVL_W(LVL_W), .TIMEOUT_BITS(TIMEOUT_BITS)) u_to (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .level(rx_level),
        .rx_char(rx_char), .rx_read(rx_read), .bit_tick(bit_tick),
        .pending(raw_status[SRC_TO])
    );

    assign masked  = raw_status & mask;
    assign irq_tx  = masked[SRC_TX];
    assign irq_rx  = masked[SRC_RX];
    assign irq_any = |masked;

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             thr_write,
    input logic             rbr_read,
    input logic [3:0]       mask,
    input logic [3:0]       raw_status,
    input logic             irq_tx,
    input logic             irq_rx,
    input logic             irq_any
);

    localparam logic [LVL_W-1:0] HALF = LVL_W'(FIFO_DEPTH / 2);

    a_r1_tx_below_half: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && tx_level < HALF |=> raw_status[0]);

    a_r1_tx_above_half: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && tx_level > HALF |=> !raw_status[0]);

    a_r2_tx_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en && thr_write |=> !raw_status[0]);

    a_r3_rx_at_half: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && rx_level >= HALF |=> raw_status[1]);

    a_r4_rx_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en && rbr_read |=> !raw_status[1]);

    a_r7_timeout_drained: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level == '0 |=> !raw_status[3]);

    a_r8_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        raw_status == 4'b0000 |-> !irq_any);

    a_r8_tx_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> irq_any && mask[0]);

    a_r8_rx_line: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> irq_any && mask[1]);

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_level(tx_level),
    .rx_level(rx_level), .thr_write(thr_write), .rbr_read(rbr_read),
    .mask(mask), .raw_status(raw_status), .irq_tx(irq_tx),
    .irq_rx(irq_rx), .irq_any(irq_any)
);

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;

    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;
    localparam int TOUT  = 32;
    localparam int LW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 1'b1;
    logic [LW-1:0] tx_level = '0;
    logic [LW-1:0] rx_level = '0;
    logic          thr_empty = 1'b0, thr_write = 1'b0;
    logic          rbr_full = 1'b0, rbr_read = 1'b0;
    logic          rx_char = 1'b0, rx_read = 1'b0, bit_tick = 1'b0;
    logic [3:0]    modem_in = '0;
    logic          modem_stat_write = 1'b0;
    logic [3:0]    mask = 4'hF;
    logic [3:0]    raw_status;
    logic          irq_tx, irq_rx, irq_any;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_level(tx_level),
        .rx_level(rx_level), .thr_empty(thr_empty), .thr_write(thr_write),
        .rbr_full(rbr_full), .rbr_read(rbr_read), .rx_char(rx_char),
        .rx_read(rx_read), .bit_tick(bit_tick), .modem_in(modem_in),
        .modem_stat_write(modem_stat_write), .mask(mask),
        .raw_status(raw_status), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .irq_any(irq_any)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FIFO? no: FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        bit_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    initial begin
        int exp_tx;
        exp_tx = 0;
        // R9: reset state
        repeat (3) step();
        chk("R9 raw", int'(raw_status), 0);
        chk("R9 any", int'(irq_any), 0);
        chk("R9 tx/rx", int'({irq_tx, irq_rx}), 0);
        rst_n = 1'b1;

        // R1: sweep transmit level up then down in FIFO mode
        fifo_en = 1'b1;
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i <= DEPTH; i++) begin
                int lv;
                lv = (d == 0) ? i : DEPTH - i;
                tx_level = LW'(lv);
                step();
                if (lv < HALF) exp_tx = 1;
                else if (lv > HALF) exp_tx = 0;
                chk($sformatf("R1 tx level %0d", lv), int'(raw_status[0]), exp_tx);
            end
        end

        // R3: sweep receive level in FIFO mode
        for (int i = 0; i <= DEPTH; i++) begin
            rx_level = LW'(i);
            step();
            chk($sformatf("R3 rx level %0d", i), int'(raw_status[1]), (i >= HALF) ? 1 : 0);
        end
        for (int i = DEPTH; i >= 0; i--) begin
            rx_level = LW'(i);
            step();
            chk($sformatf("R3 rx level down %0d", i), int'(raw_status[1]), (i >= HALF) ? 1 : 0);
        end

        // R2: single-register transmit rules
        fifo_en = 1'b0; rx_level = '0;
        thr_empty = 1'b1; step();
        chk("R2 empty sets", int'(raw_status[0]), 1);
        thr_write = 1'b1; step();
        chk("R2 write wins", int'(raw_status[0]), 0);
        thr_write = 1'b0; thr_empty = 1'b0; step();
        chk("R2 stays clear", int'(raw_status[0]), 0);
        thr_empty = 1'b1; step();
        chk("R2 empty again", int'(raw_status[0]), 1);
        thr_empty = 1'b0; step();
        chk("R2 holds until write", int'(raw_status[0]), 1);
        thr_write = 1'b1; step(); thr_write = 1'b0;
        chk("R2 write clears", int'(raw_status[0]), 0);

        // R4: single-register receive rules
        rbr_full = 1'b1; step();
        chk("R4 full sets", int'(raw_status[1]), 1);
        rbr_read = 1'b1; step();
        chk("R4 read clears", int'(raw_status[1]), 0);
        rbr_read = 1'b0; rbr_full = 1'b0; step();
        chk("R4 stays clear", int'(raw_status[1]), 0);

        // R6: no timeout in single-register mode
        rx_level = LW'(1); step();
        ticks(TOUT + 8);
        chk("R6 no timeout without fifo", int'(raw_status[3]), 0);

        // R6: exact expiry in FIFO mode
        fifo_en = 1'b1; rx_level = '0; step();
        rx_level = LW'(1); step();
        ticks(TOUT - 1);
        chk("R6 one tick short", int'(raw_status[3]), 0);
        ticks(1);
        chk("R6 expiry", int'(raw_status[3]), 1);

        // R7: drain clears, restart by rx_char
        rx_level = '0; step();
        chk("R7 drained clears", int'(raw_status[3]), 0);
        rx_level = LW'(1); step();
        ticks(20);
        rx_char = 1'b1; step(); rx_char = 1'b0;
        ticks(TOUT - 1);
        chk("R7 char restarts count", int'(raw_status[3]), 0);
        ticks(1);
        chk("R7 fires after restart", int'(raw_status[3]), 1);
        rx_read = 1'b1; step(); rx_read = 1'b0; step();
        chk("R7 read does not clear", int'(raw_status[3]), 1);

        // R5: modem change through synchronizer
        modem_in = 4'b0010;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R5 not before third edge", int'(raw_status[2]), 0);
        step();
        chk("R5 set on third edge", int'(raw_status[2]), 1);
        repeat (3) step();
        chk("R5 sticky", int'(raw_status[2]), 1);
        modem_stat_write = 1'b1; step(); modem_stat_write = 1'b0;
        chk("R5 write clears", int'(raw_status[2]), 0);
        modem_in = 4'b1010; repeat (4) step();
        chk("R5 second change", int'(raw_status[2]), 1);

        // R8: all four pending, sweep masks
        tx_level = '0; rx_level = LW'(DEPTH); step(); step();
        chk("R8 all raw pending", int'(raw_status), 15);
        for (int m = 0; m < 16; m++) begin
            mask = 4'(m);
            #1;
            chk($sformatf("R8 tx m=%0d", m), int'(irq_tx), m & 1);
            chk($sformatf("R8 rx m=%0d", m), int'(irq_rx), (m >> 1) & 1);
            chk($sformatf("R8 any m=%0d", m), int'(irq_any), (m != 0) ? 1 : 0);
            chk($sformatf("R8 raw unmasked m=%0d", m), int'(raw_status), 15);
            step();
        end

        // R8: none pending
        tx_level = LW'(DEPTH); rx_level = '0; modem_stat_write = 1'b1;
        step(); modem_stat_write = 1'b0; step();
        chk("R8 raw all clear", int'(raw_status), 0);
        for (int m = 0; m < 16; m++) begin
            mask = 4'(m);
            #1;
            chk($sformatf("R8 quiet any m=%0d", m), int'(irq_any), 0);
        end

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule